// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, seven or eight data bits in either bit order, an optional parity bit and one or two high stop bits. The line rests high between frames. An 8-bit control word sets the framing, and a 16-bit divider sets the bit rate. Each bit lasts twice the divider value in clock cycles, and any divider below four counts as four.

A client offers a byte by pulsing the write strobe for one cycle. The block takes the byte only when it is powered, transmit-enabled and idle. From the next cycle `busy_o` stays high until the last stop bit has been on the line for its full period. In the cycle `busy_o` drops, `irq_o` pulses for one cycle. The framing and the divider are captured with the byte, so the client may rewrite them while a frame is going out. Clearing either enable bit abandons the frame at once.

Top module: `uart_tx_unit`

## Requirements
- R1: After reset `txd_o` is 1, `busy_o` is 0 and `irq_o` is 0; the line is 1 whenever `busy_o` is 0.
- R2: An accepted frame begins with a 0 start bit in the cycle after the accepting edge and ends with stop bits at 1; each bit holds for 2*N cycles, where N is the captured divider.
- R3: A divider value of 0, 1, 2 or 3 gives the same 8-cycle bit period as a value of 4.
- R4: Control bit 2 set sends 8 data bits; clear sends only data bits 6..0, and bit 7 of the byte never reaches the line.
- R5: Control bits 4:3 choose parity: 00 adds no parity bit, 01 adds a bit fixed at 0, 10 adds a bit making the count of ones in data plus parity odd, 11 makes it even; only the data bits actually sent are counted.
- R6: Control bit 1 set sends two stop bits; clear sends one.
- R7: Control bit 5 set sends the data least significant bit first; clear sends the most significant sent bit first (bit 7, or bit 6 in 7-bit mode).
- R8: `busy_o` is 1 from the cycle after an accepted write through the last cycle of the final stop bit; a write strobe while `busy_o` is 1 is ignored.
- R9: `irq_o` is high for exactly one cycle, the cycle in which `busy_o` falls at the end of a complete frame.
- R10: A write is accepted only when control bits 7 (power) and 6 (transmit enable) are both 1; clearing either one during a frame ends it on the next edge with the line at 1 and no `irq_o` pulse.
- R11: Framing bits and the divider are captured at the accepting edge; changing them mid-frame, with both enables kept set, does not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_i | input | 8 | Control word: 7 power, 6 transmit enable, 5 LSB-first, 4:3 parity mode, 2 eight-bit length, 1 two stop bits, 0 spare |
| div_i | input | 16 | Half bit period in clock cycles (values below 4 act as 4) |
| wr_i | input | 1 | One-cycle strobe offering `data_i` |
| data_i | input | 8 | Character to send |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |
| irq_o | output | 1 | One-cycle pulse when a frame has fully left the line |

## Verification
A bit counter that wraps at the wrong value moves every later bit edge. Sampling each bit at its middle shows a stretched or shortened period as a wrong line level within the next one or two bits. A bit index that skips or sticks puts a data, parity or stop level in the wrong slot, and the next mid-bit sample shows it. A busy or interrupt flag that ends early or late is caught in the exact cycle the frame should close, because the bench checks both flags one cycle before and one cycle after that point.

// File: rtl/uart_tx_pkg.sv
// Package: shared widths and the control-word layout for the serial transmitter.
// Assumes one character of at most DATA_W bits per frame.
package uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 4;           // start + data + parity + 2 stops
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int DIV_W   = 16;
    localparam int DIV_MIN = 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    // Control word, MSB first: pwr, txen, lsb_first, par[1:0], len8, stop2, spare
    typedef struct packed {
        logic      pwr;
        logic      txen;
        logic      lsb_first;
        par_mode_e par;
        logic      len8;
        logic      stop2;
        logic      spare;
    } ctrl_t;

endpackage

// File: rtl/uart_tx_baud.sv
// Bit-period timer: pulses tick once every 2*max(div, DIV_MIN) cycles while run is high.
// Assumes restart arrives in the cycle the frame is accepted, so the first bit gets a full period.
module uart_tx_baud #(
    parameter int DIV_W   = 16,
    parameter int DIV_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] eff_div;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt_q;

    // Clamp the divider to its floor and double it into a full bit period.
    always_comb begin
        eff_div = (div < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div;
        period  = {eff_div, 1'b0};
        tick    = run && (cnt_q == period - CNT_W'(1));
    end

    // Count cycles inside the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (restart || !run) cnt_q <= '0;
        else if (tick)            cnt_q <= '0;
        else                      cnt_q <= cnt_q + CNT_W'(1);
    end

    a_r2_cnt_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < period));

    a_r3_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        period >= CNT_W'(2 * DIV_MIN));

endmodule

// File: rtl/uart_tx_framer.sv
// Frame builder: lays out start, ordered data, parity and stop levels for one character.
// Assumes unused high positions of the frame vector are 1 (line idle level).
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  ctrl_t              cfg,
    input  logic [DATA_W-1:0]  data,
    output logic [FRAME_W-1:0] frame,
    output logic [IDX_W-1:0]   nbits
);
    logic [DATA_W-1:0] rev;
    logic [DATA_W-1:0] ordered;
    logic [DATA_W-1:0] sent_mask;
    logic              ones_odd;
    logic              par_bit;
    int                total;

    // Reverse the byte so MSB-first order is a plain slice.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) rev[i] = data[DATA_W-1-i];
    end

    // Choose bit order and the parity level over the bits that go out.
    always_comb begin
        if (cfg.lsb_first)  ordered = data;
        else if (cfg.len8)  ordered = rev;
        else                ordered = rev >> 1;
        sent_mask = cfg.len8 ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
        ones_odd  = ^(ordered & sent_mask);
        unique case (cfg.par)
            PAR_ODD:  par_bit = ~ones_odd;
            PAR_EVEN: par_bit = ones_odd;
            default:  par_bit = 1'b0;
        endcase
    end

    // Place the fields into the frame and count its length.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        if (cfg.len8) frame[DATA_W:1] = ordered;
        else          frame[DATA_W-1:1] = ordered[DATA_W-2:0];
        if (cfg.par != PAR_NONE) begin
            if (cfg.len8) frame[DATA_W+1] = par_bit;
            else          frame[DATA_W]   = par_bit;
        end
        total = 1 + (cfg.len8 ? DATA_W : DATA_W - 1)
                  + ((cfg.par != PAR_NONE) ? 1 : 0)
                  + (cfg.stop2 ? 2 : 1);
        nbits = IDX_W'(total);
    end

endmodule

// File: rtl/uart_tx_unit.sv
// Serial transmitter top: accepts a byte when enabled and idle, shifts the frame out
// at the captured bit rate, and flags completion with a one-cycle interrupt.
// Assumes ctrl_i and div_i are synchronous to clk; wr_i is a one-cycle strobe.
module uart_tx_unit
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ctrl_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              txd_o,
    output logic              busy_o,
    output logic              irq_o
);
    ctrl_t              cfg;
    logic               enabled;
    logic               accept;
    logic               tick;
    logic               spare_unused;
    logic [FRAME_W-1:0] frame_w;
    logic [IDX_W-1:0]   nbits_w;

    logic               busy_q;
    logic               irq_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   nbits_q;
    logic [FRAME_W-1:0] frame_q;
    logic [DIV_W-1:0]   div_q;

    // Decode the control word and the acceptance condition.
    always_comb begin
        cfg          = ctrl_t'(ctrl_i);
        spare_unused = cfg.spare;
        enabled      = cfg.pwr && cfg.txen;
        accept       = wr_i && enabled && !busy_q;
    end

    uart_tx_framer u_framer (
        .cfg   (cfg),
        .data  (data_i),
        .frame (frame_w),
        .nbits (nbits_w)
    );

    uart_tx_baud #(
        .DIV_W   (DIV_W),
        .DIV_MIN (DIV_MIN)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy_q),
        .div     (div_q),
        .tick    (tick)
    );

    // Frame sequencer: capture on accept, advance on tick, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            irq_q   <= 1'b0;
            idx_q   <= '0;
            nbits_q <= '0;
            frame_q <= '1;
            div_q   <= DIV_W'(DIV_MIN);
        end else begin
            irq_q <= 1'b0;
            if (!enabled) begin
                busy_q <= 1'b0;
            end else if (accept) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                frame_q <= frame_w;
                nbits_q <= nbits_w;
                div_q   <= div_i;
            end else if (busy_q && tick) begin
                if (idx_q == nbits_q - IDX_W'(1)) begin
                    busy_q <= 1'b0;
                    irq_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    // Drive the line from the captured frame, idle high otherwise.
    always_comb begin
        txd_o  = busy_q ? frame_q[idx_q] : 1'b1;
        busy_o = busy_q;
        irq_o  = irq_q;
    end

    a_r9_irq_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!busy_q && $past(busy_q)));

    a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> !txd_o);

    a_r8_index_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q < nbits_q));

    a_r11_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(frame_q) && $stable(div_q)));

    a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> (!busy_q && !irq_q));

endmodule

// File: tb/uart_tx_unit_bench.sv
module uart_tx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctrl_i = 8'h00;
    logic [15:0] div_i = 16'd4;
    logic        wr_i = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic        txd_o, busy_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit skip_mon = 1'b0;
    bit done = 1'b0;

    logic [15:0] q_bits[$];
    int          q_len[$];
    int          q_per[$];
    string       q_tag[$];

    localparam logic [7:0] EN = 8'hC0, LSB = 8'h20, PZ = 8'h08, PO = 8'h10,
                           PE = 8'h18, L8 = 8'h04, S2 = 8'h02;

    always #10 clk = ~clk;   // 50 MHz

    uart_tx_unit u_uart_tx_unit (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .div_i(div_i),
        .wr_i(wr_i), .data_i(data_i), .txd_o(txd_o), .busy_o(busy_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected line levels from the requirements (R2, R4, R5, R6, R7).
    function automatic void build(input logic [7:0] c, input logic [7:0] d,
                                  output logic [15:0] b, output int n);
        int  dl;
        int  k;
        bit  x;
        bit  v;
        dl = c[2] ? 8 : 7;
        b = '1;
        x = 1'b0;
        b[0] = 1'b0;
        k = 1;
        for (int i = 0; i < dl; i++) begin
            v = c[5] ? d[i] : d[dl-1-i];
            b[k] = v;
            x = x ^ v;
            k = k + 1;
        end
        case (c[4:3])
            2'b01: begin b[k] = 1'b0; k = k + 1; end
            2'b10: begin b[k] = ~x;   k = k + 1; end
            2'b11: begin b[k] = x;    k = k + 1; end
            default: ;
        endcase
        k = k + (c[1] ? 2 : 1);
        n = k;
    endfunction

    // Driver: push the expected frame, strobe the byte, optionally disturb it.
    task automatic send(input logic [7:0] c, input logic [15:0] d, input logic [7:0] data,
                        input string tag, input bit poke, input bit recfg);
        logic [15:0] b;
        int          n;
        build(c, data, b, n);
        q_bits.push_back(b);
        q_len.push_back(n);
        q_per.push_back(2 * ((d < 16'd4) ? 4 : int'(d)));
        q_tag.push_back(tag);
        @(negedge clk);
        ctrl_i = c; div_i = d; data_i = data; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            data_i = ~data; wr_i = 1'b1;
            @(negedge clk);
            wr_i = 1'b0;
        end
        if (recfg) begin
            repeat (3) @(negedge clk);
            ctrl_i = c ^ 8'h3E;
            div_i = d + 16'd7;
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R8 no frame from ignored write", int'(busy_o), 0);
    endtask

    // Monitor: compare each started frame against the scoreboard queue.
    initial begin
        bit prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (busy_o && !prev && !skip_mon) begin
                if (q_bits.size() == 0) begin
                    chk(1'b0, "R8 unexpected frame", 1, 0);
                end else begin
                    logic [15:0] b;
                    int n, p, c;
                    string t;
                    b = q_bits.pop_front(); n = q_len.pop_front();
                    p = q_per.pop_front();  t = q_tag.pop_front();
                    c = 0;
                    while (1) begin
                        if (c == 0) chk(irq_o == 1'b0, "R9 no irq at start", int'(irq_o), 0);
                        if (c < n * p && (c % p) == p / 2)
                            chk(txd_o == b[c / p], t, int'(txd_o), int'(b[c / p]));
                        if (c == n * p - 1) chk(busy_o == 1'b1, "R8 busy through last stop", int'(busy_o), 1);
                        if (c == n * p) begin
                            chk(busy_o == 1'b0, "R8 busy falls at frame end", int'(busy_o), 0);
                            chk(irq_o == 1'b1, "R9 irq at frame end", int'(irq_o), 1);
                        end
                        if (c == n * p + 1) begin
                            chk(irq_o == 1'b0, "R9 irq one cycle", int'(irq_o), 0);
                            break;
                        end
                        @(negedge clk);
                        c++;
                    end
                end
            end
            prev = busy_o;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd_o == 1'b1, "R1 idle line", int'(txd_o), 1);
        chk(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
        chk(irq_o == 1'b0, "R1 irq reset", int'(irq_o), 0);

        send(EN | LSB | L8, 16'd4, 8'hA5, "R2 R7 lsb first 8N1", 0, 0);
        send(EN | L8, 16'd5, 8'h3C, "R7 msb first 8N1", 0, 0);
        send(EN | LSB, 16'd4, 8'hD3, "R4 7-bit lsb first", 0, 0);
        send(EN, 16'd4, 8'h5A, "R4 R7 7-bit msb first", 0, 0);
        send(EN | LSB | L8 | PO, 16'd4, 8'h07, "R5 odd parity", 0, 0);
        send(EN | LSB | L8 | PE, 16'd4, 8'h07, "R5 even parity", 0, 0);
        send(EN | L8 | PZ, 16'd4, 8'hFF, "R5 zero parity", 0, 0);
        send(EN | LSB | PE, 16'd4, 8'h81, "R5 R4 parity over sent bits", 0, 0);
        send(EN | LSB | L8 | PO | S2, 16'd6, 8'h96, "R6 two stop bits", 0, 0);
        send(EN | S2, 16'd4, 8'h01, "R6 two stops 7-bit", 0, 0);
        send(EN | LSB | L8, 16'd0, 8'h6E, "R3 divider 0", 0, 0);
        send(EN | L8, 16'd1, 8'h91, "R3 divider 1", 0, 0);
        send(EN | LSB | L8, 16'd3, 8'hC4, "R3 divider 3", 0, 0);
        send(EN | LSB | L8 | PE, 16'd4, 8'h2B, "R8 write while busy ignored", 1, 0);
        send(EN | LSB | L8, 16'd5, 8'hE1, "R11 config change mid-frame", 0, 1);

        // R10: writes refused without both enables.
        @(negedge clk);
        ctrl_i = 8'h40 | LSB | L8; data_i = 8'h55; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chk(busy_o == 1'b0 && txd_o == 1'b1, "R10 power off refuses write", int'(busy_o), 0);
            @(negedge clk);
        end
        ctrl_i = 8'h80 | LSB | L8; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chk(busy_o == 1'b0 && txd_o == 1'b1, "R10 tx disabled refuses write", int'(busy_o), 0);
            @(negedge clk);
        end

        // R10: abort mid-frame.
        skip_mon = 1'b1;
        ctrl_i = EN | LSB | L8; div_i = 16'd4; data_i = 8'h00; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy_o == 1'b1, "R10 frame running before abort", int'(busy_o), 1);
        ctrl_i = 8'h00;
        @(negedge clk);
        chk(busy_o == 1'b0, "R10 abort clears busy", int'(busy_o), 0);
        chk(txd_o == 1'b1, "R10 abort line high", int'(txd_o), 1);
        for (int i = 0; i < 40; i++) begin
            chk(irq_o == 1'b0, "R10 no irq after abort", int'(irq_o), 0);
            @(negedge clk);
        end
        skip_mon = 1'b0;

        repeat (5) @(negedge clk);
        chk(q_bits.size() == 0, "R2 all frames observed", q_bits.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule